// File: doc/BRIEF.md
# Timestamped Event-Cluster Capture Packer

This block is the front end of a logic-capture path. On each event tick it turns one sampled channel bus into a 16-bit event word. In the faster rate modes fewer channels are sampled several times per event, and the block bit-interleaves those sub-samples into the word. Seven event words and a 16-bit timestamp form one cluster. The block hands each cluster, complete, to the sample memory writer, together with the word address it belongs at.

The timestamp counter is free-running in event periods and keeps counting while capture is idle. A later decoder can therefore rebuild gaps by repeating the last sample value. A trigger pulse latches the word position of the event it belongs to. A stop pulse, or the end of the post-trigger window, latches the stop position. Both 24-bit positions are read back one byte at a time. Positions count 16-bit words, so one 1024-byte chunk spans 512 units and a cluster spans 8.

Top module: `cap_packer`

## Requirements
- R1: In the cycle after reset is released, `cl_valid`, `trig_fired` and `capturing` are 0, and all six readback bytes are 0.
- R2: With `mode` 0 or 3 (16 channels, one sample per event), the event word equals `smp_bus` bit for bit.
- R3: With `mode` 1 (8 channels, two samples per event), `smp_bus` bit k*8+l (sub-sample k of channel l, k=0 earliest) lands at event word bit l*2+k.
- R4: With `mode` 2 (4 channels, four samples per event), `smp_bus` bit k*4+l lands at event word bit l*4+k.
- R5: A tick with `capturing` high records one event. After the seventh recorded event, `cl_valid` is high for exactly the next cycle. `cl_data[15:0]` then holds the timestamp counter value at the cluster's first event, and event j (0 = first) sits at `cl_data[16*j+31 -: 16]`.
- R6: The timestamp counter starts at 0 after reset and advances on every `ev_tick`, whether capture is running or not.
- R7: The first cluster after `start` has `cl_pos` 0, and each later cluster's `cl_pos` is 8 above the previous one.
- R8: While capturing, the first `trig` pulse sets `trig_fired` and latches the trigger position as (cl_pos of the open cluster) + 1 + (events already in it). Later pulses change nothing until the next `start`.
- R9: A `stop` pulse while capturing clears `capturing` on the next cycle. A tick in the same cycle is still recorded. The stop position is the word address after the last complete cluster, including one completed in that cycle. A partial cluster is dropped, and ticks while idle emit nothing.
- R10: `rd_sel` 0,1,2 return trigger position bits [7:0],[15:8],[23:16]. `rd_sel` 3,4,5 return the same bytes of the stop position. `rd_sel` 6,7 return 0.
- R11: At `start` the post-trigger length is latched as min(`ratio`,100)*255/100, using integer division. Once the trigger has fired and that many clusters have been emitted after it, capture stops on the following cycle, with the stop position latched as in R9.
- R12: `start` begins a capture. It clears both positions, `trig_fired`, the open cluster and the write position, but not the timestamp counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a capture (pulse) |
| stop | input | 1 | End a capture (pulse) |
| mode | input | 2 | Rate mode: 0/3 = 16 ch, 1 = 8 ch, 2 = 4 ch |
| ratio | input | 7 | Post-trigger percentage, latched at start |
| ev_tick | input | 1 | One pulse per event period |
| smp_bus | input | 16 | Sub-samples for this event, earliest in low bits |
| trig | input | 1 | Trigger condition pulse |
| rd_sel | input | 3 | Readback byte select |
| rd_data | output | 8 | Selected position byte |
| trig_fired | output | 1 | Trigger position latched |
| capturing | output | 1 | Capture running |
| cl_valid | output | 1 | Cluster output valid (one cycle) |
| cl_data | output | 128 | Timestamp plus seven event words |
| cl_pos | output | 24 | Word address of the emitted cluster |

## Verification
Two functions can land on the same edge: a `stop` pulse and the tick that fills the seventh slot of a cluster. The bench drives both in one cycle. It then requires that the cluster still appears, carrying the last event word, and that `capturing` falls. It also requires that the stop position read back already counts that cluster (8, not 0). The same meeting happens through the post-trigger window: the stop comes from the count of emitted clusters, and that stop position must also include the final cluster.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        MODE_X1  = 2'd0,
        MODE_X2  = 2'd1,
        MODE_X4  = 2'd2,
        MODE_ALT = 2'd3
    } rate_mode_e;

    localparam int RATIO_MAX  = 100;
    localparam int POST_SCALE = 255;

    // Post-trigger cluster budget derived from the percentage input.
    function automatic logic [7:0] post_len_of(input logic [6:0] pct);
        int unsigned r;
        int unsigned p;
        r = (int'(pct) > RATIO_MAX) ? RATIO_MAX : int'(pct);
        p = (r * POST_SCALE) / RATIO_MAX;
        return p[7:0];
    endfunction

    // Number of readback bytes per latched position.
    function automatic int pos_bytes(input int pos_w);
        return (pos_w + 7) / 8;
    endfunction

endpackage

// File: rtl/cap_interleave.sv
module cap_interleave
    import cap_pkg::*;
#(
    parameter int CH = 16
) (
    input  rate_mode_e       mode,
    input  logic [CH-1:0]    bus,
    output logic [CH-1:0]    word
);
    localparam int C2 = CH / 2;
    localparam int C4 = CH / 4;

    logic [CH-1:0] w2;
    logic [CH-1:0] w4;

    // Two sub-samples per event: bus is time-major, word is channel-major.
    for (genvar l = 0; l < C2; l++) begin : g_x2_ch
        for (genvar k = 0; k < 2; k++) begin : g_x2_sub
            assign w2[l*2+k] = bus[k*C2+l];
        end
    end

    // Four sub-samples per event.
    for (genvar l = 0; l < C4; l++) begin : g_x4_ch
        for (genvar k = 0; k < 4; k++) begin : g_x4_sub
            assign w4[l*4+k] = bus[k*C4+l];
        end
    end

    always_comb begin
        case (mode)
            MODE_X2: word = w2;
            MODE_X4: word = w4;
            default: word = bus;
        endcase
    end

endmodule

// File: rtl/cap_cluster.sv
module cap_cluster #(
    parameter int CH     = 16,
    parameter int EV     = 7,
    parameter int TS_W   = 16,
    parameter int POS_W  = 24,
    parameter int SLOT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   rec,
    input  logic                   ev_tick,
    input  logic [CH-1:0]          ev_word,
    output logic [SLOT_W-1:0]      slot,
    output logic                   emit_now,
    output logic [POS_W-1:0]       wr_pos,
    output logic                   cl_valid,
    output logic [TS_W+EV*CH-1:0]  cl_data,
    output logic [POS_W-1:0]       cl_pos
);
    localparam int LAST = EV - 1;
    localparam int WPC  = EV + 1;
    localparam int CL_W = TS_W + EV * CH;

    typedef struct packed {
        logic [EV-1:0][CH-1:0] ev;
        logic [TS_W-1:0]       ts;
    } cluster_t;

    logic [TS_W-1:0]          tcount;
    logic [TS_W-1:0]          ts_hold;
    logic [LAST-1:0][CH-1:0]  evbuf;
    logic [TS_W-1:0]          ts_now;
    cluster_t                 asm_cl;

    assign emit_now = rec && (slot == SLOT_W'(LAST));
    assign ts_now   = (slot == '0) ? tcount : ts_hold;

    always_comb begin
        asm_cl.ts = ts_now;
        for (int j = 0; j < EV; j++) begin
            if (j == LAST) asm_cl.ev[j] = ev_word;
            else           asm_cl.ev[j] = evbuf[j];
        end
    end

    // Free-running event-period counter.
    always_ff @(posedge clk) begin
        if (rst)          tcount <= '0;
        else if (ev_tick) tcount <= tcount + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= '0;
            wr_pos   <= '0;
            ts_hold  <= '0;
            evbuf    <= '0;
            cl_valid <= 1'b0;
            cl_data  <= '0;
            cl_pos   <= '0;
        end else if (clr) begin
            slot     <= '0;
            wr_pos   <= '0;
            cl_valid <= 1'b0;
        end else begin
            cl_valid <= emit_now;
            if (rec) begin
                if (slot == '0) ts_hold <= tcount;
                if (emit_now) begin
                    cl_data <= CL_W'(asm_cl);
                    cl_pos  <= wr_pos;
                    wr_pos  <= wr_pos + POS_W'(WPC);
                    slot    <= '0;
                end else begin
                    evbuf[slot] <= ev_word;
                    slot        <= slot + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cap_marks.sv
module cap_marks
    import cap_pkg::*;
#(
    parameter int EV     = 7,
    parameter int POS_W  = 24,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              trig,
    input  logic [6:0]        ratio,
    input  logic              emit_now,
    input  logic [SLOT_W-1:0] slot,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [2:0]        rd_sel,
    output logic              active,
    output logic              fired,
    output logic [7:0]        rd_data
);
    localparam int WPC = EV + 1;
    localparam int NB  = pos_bytes(POS_W);
    localparam int PW  = NB * 8;

    logic [POS_W-1:0] trig_pos;
    logic [POS_W-1:0] stop_pos;
    logic [7:0]       post_len;
    logic [7:0]       post_cnt;
    logic             auto_stop;
    logic [PW-1:0]    trig_ext;
    logic [PW-1:0]    stop_ext;

    assign auto_stop = active && fired && (post_cnt == post_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            fired    <= 1'b0;
            trig_pos <= '0;
            stop_pos <= '0;
            post_len <= '0;
            post_cnt <= '0;
        end else if (start) begin
            active   <= 1'b1;
            fired    <= 1'b0;
            trig_pos <= '0;
            stop_pos <= '0;
            post_cnt <= '0;
            post_len <= post_len_of(ratio);
        end else begin
            if (active && trig && !fired) begin
                fired    <= 1'b1;
                trig_pos <= wr_pos + POS_W'(1) + POS_W'(slot);
            end
            if (fired && emit_now && post_cnt != 8'hFF)
                post_cnt <= post_cnt + 1'b1;
            if (active && (stop || auto_stop)) begin
                active   <= 1'b0;
                stop_pos <= wr_pos + (emit_now ? POS_W'(WPC) : '0);
            end
        end
    end

    assign trig_ext = PW'(trig_pos);
    assign stop_ext = PW'(stop_pos);

    always_comb begin
        rd_data = 8'h00;
        for (int b = 0; b < 3; b++) begin
            if (b < NB) begin
                if (rd_sel == 3'(b))     rd_data = trig_ext[b*8 +: 8];
                if (rd_sel == 3'(b + 3)) rd_data = stop_ext[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/cap_packer.sv
module cap_packer
    import cap_pkg::*;
#(
    parameter int CH    = 16,
    parameter int EV    = 7,
    parameter int TS_W  = 16,
    parameter int POS_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   stop,
    input  logic [1:0]             mode,
    input  logic [6:0]             ratio,
    input  logic                   ev_tick,
    input  logic [CH-1:0]          smp_bus,
    input  logic                   trig,
    input  logic [2:0]             rd_sel,
    output logic [7:0]             rd_data,
    output logic                   trig_fired,
    output logic                   capturing,
    output logic                   cl_valid,
    output logic [TS_W+EV*CH-1:0]  cl_data,
    output logic [POS_W-1:0]       cl_pos
);
    localparam int SLOT_W = (EV > 1) ? $clog2(EV) : 1;

    logic [CH-1:0]     ev_word;
    logic [SLOT_W-1:0] slot;
    logic              emit_now;
    logic [POS_W-1:0]  wr_pos;
    logic              rec;

    assign rec = capturing && ev_tick && !start;

    cap_interleave #(.CH(CH)) u_ilv (
        .mode (rate_mode_e'(mode)),
        .bus  (smp_bus),
        .word (ev_word)
    );

    cap_cluster #(
        .CH(CH), .EV(EV), .TS_W(TS_W), .POS_W(POS_W), .SLOT_W(SLOT_W)
    ) u_cl (
        .clk      (clk),
        .rst      (rst),
        .clr      (start),
        .rec      (rec),
        .ev_tick  (ev_tick),
        .ev_word  (ev_word),
        .slot     (slot),
        .emit_now (emit_now),
        .wr_pos   (wr_pos),
        .cl_valid (cl_valid),
        .cl_data  (cl_data),
        .cl_pos   (cl_pos)
    );

    cap_marks #(
        .EV(EV), .POS_W(POS_W), .SLOT_W(SLOT_W)
    ) u_mk (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .trig     (trig),
        .ratio    (ratio),
        .emit_now (emit_now),
        .slot     (slot),
        .wr_pos   (wr_pos),
        .rd_sel   (rd_sel),
        .active   (capturing),
        .fired    (trig_fired),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/cap_packer_chk.sv
module cap_packer_chk #(
    parameter int EV    = 7,
    parameter int POS_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             stop,
    input logic             cl_valid,
    input logic [POS_W-1:0] cl_pos,
    input logic             trig_fired,
    input logic             capturing
);
    logic             seen;
    logic [POS_W-1:0] last_pos;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            seen     <= 1'b0;
            last_pos <= '0;
        end else if (cl_valid) begin
            seen     <= 1'b1;
            last_pos <= cl_pos;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!cl_valid && !trig_fired && !capturing)); // R1

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cl_valid |=> !cl_valid); // R5

    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (cl_valid && seen) |-> (cl_pos == last_pos + POS_W'(EV + 1))); // R7

    AST_FIRED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (trig_fired && !start) |=> trig_fired); // R8

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (stop && capturing && !start) |=> !capturing); // R9

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !capturing |=> !cl_valid); // R9

    AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
        start |=> (capturing && !trig_fired)); // R12

endmodule

bind cap_packer cap_packer_chk #(.EV(EV), .POS_W(POS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .stop       (stop),
    .cl_valid   (cl_valid),
    .cl_pos     (cl_pos),
    .trig_fired (trig_fired),
    .capturing  (capturing)
);

// File: tb/sim_cap_packer.sv
module sim_cap_packer;

    logic         clk = 1'b0;
    logic         rst, start, stop, ev_tick, trig;
    logic [1:0]   mode;
    logic [6:0]   ratio;
    logic [15:0]  smp_bus;
    logic [2:0]   rd_sel;
    logic [7:0]   rd_data;
    logic         trig_fired, capturing, cl_valid;
    logic [127:0] cl_data;
    logic [23:0]  cl_pos;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    cap_packer u0 (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .mode(mode),
        .ratio(ratio), .ev_tick(ev_tick), .smp_bus(smp_bus), .trig(trig),
        .rd_sel(rd_sel), .rd_data(rd_data), .trig_fired(trig_fired),
        .capturing(capturing), .cl_valid(cl_valid), .cl_data(cl_data),
        .cl_pos(cl_pos)
    );

    // mode, input bus, expected event word
    localparam logic [33:0] VEC [8] = '{
        {2'd0, 16'hA5C3, 16'hA5C3},
        {2'd3, 16'h1234, 16'h1234},
        {2'd1, 16'h00FF, 16'h5555},
        {2'd1, 16'hFF00, 16'hAAAA},
        {2'd1, 16'h0F01, 16'h00AB},
        {2'd2, 16'h000F, 16'h1111},
        {2'd2, 16'h1111, 16'h000F},
        {2'd2, 16'h0003, 16'h0011}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic tk, input logic [15:0] b, input logic st,
                       input logic tg, input logic sr);
        ev_tick = tk; smp_bus = b; stop = st; trig = tg; start = sr;
        @(negedge clk);
        ev_tick = 0; stop = 0; trig = 0; start = 0;
    endtask

    task automatic rd24(input logic [2:0] base, output logic [23:0] v);
        for (int i = 0; i < 3; i++) begin
            rd_sel = base + 3'(i);
            #1;
            v[i*8 +: 8] = rd_data;
        end
    endtask

    function automatic logic [15:0] ev_at(input logic [127:0] d, input int j);
        return d[16*j+16 +: 16];
    endfunction

    function automatic string req_of(input logic [1:0] m);
        return (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R2";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [23:0] v;
        logic        bad_any;
        rst = 1; start = 0; stop = 0; ev_tick = 0; trig = 0;
        mode = 0; ratio = 7'd100; smp_bus = 0; rd_sel = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 cl_valid", 128'(cl_valid), 0);
        chk("R1 trig_fired", 128'(trig_fired), 0);
        chk("R1 capturing", 128'(capturing), 0);
        rd24(3'd0, v); chk("R1 trig pos", 128'(v), 0);
        rd24(3'd3, v); chk("R1 stop pos", 128'(v), 0);

        // Timestamp and position: 3 idle ticks, counter becomes 3 (R6)
        for (int i = 0; i < 3; i++) cyc(1, 16'h0, 0, 0, 0);
        chk("R9 idle tick no cluster", 128'(cl_valid), 0);
        cyc(0, 0, 0, 0, 1);
        for (int j = 0; j < 7; j++) cyc(1, 16'h0100 + 16'(j), 0, 0, 0);
        chk("R5 valid", 128'(cl_valid), 1);
        chk("R6 ts after idle ticks", 128'(cl_data[15:0]), 3);
        bad_any = 0;
        for (int j = 0; j < 7; j++) if (ev_at(cl_data, j) !== 16'h0100 + 16'(j)) bad_any = 1;
        chk("R5 event order", 128'(bad_any), 0);
        chk("R7 first pos", 128'(cl_pos), 0);
        @(negedge clk);
        chk("R5 valid one cycle", 128'(cl_valid), 0);
        for (int j = 0; j < 7; j++) cyc(1, 16'h0200 + 16'(j), 0, 0, 0);
        chk("R5 second ts", 128'(cl_data[15:0]), 10);
        chk("R7 second pos", 128'(cl_pos), 8);
        cyc(1, 16'hFFFF, 0, 0, 0);          // partial cluster, dropped at stop
        cyc(0, 0, 1, 0, 0);
        chk("R9 stop clears capturing", 128'(capturing), 0);
        rd24(3'd3, v); chk("R9 stop pos drops partial", 128'(v), 16);
        rd_sel = 3'd3; #1; chk("R10 stop byte0", 128'(rd_data), 8'h10);
        rd_sel = 3'd6; #1; chk("R10 sel6 zero", 128'(rd_data), 0);
        bad_any = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(1, 16'h5A5A, 0, 0, 0);
            if (cl_valid) bad_any = 1;
        end
        chk("R9 idle ticks ignored", 128'(bad_any), 0);
        cyc(0, 0, 0, 0, 1);
        rd24(3'd3, v); chk("R12 start clears stop pos", 128'(v), 0);
        chk("R12 capturing", 128'(capturing), 1);
        for (int j = 0; j < 7; j++) cyc(1, 16'h0300, 0, 0, 0);
        chk("R6 ts kept counting", 128'(cl_data[15:0]), 30);
        chk("R12 pos restarts", 128'(cl_pos), 0);

        // Vector table: interleave modes (R2 R3 R4)
        foreach (VEC[i]) begin
            mode = VEC[i][33:32];
            cyc(0, 0, 0, 0, 1);
            for (int j = 0; j < 7; j++) cyc(1, VEC[i][31:16], 0, 0, 0);
            bad_any = 0;
            for (int j = 0; j < 7; j++) if (ev_at(cl_data, j) !== VEC[i][15:0]) bad_any = 1;
            chk(req_of(mode), 128'(ev_at(cl_data, 0)), 128'(VEC[i][15:0]));
            chk({req_of(mode), " all slots"}, 128'(bad_any), 0);
        end
        mode = 0;

        // Trigger position R8 R10
        ratio = 7'd100;
        cyc(0, 0, 0, 0, 1);
        for (int j = 0; j < 3; j++) cyc(1, 16'h1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R8 fired", 128'(trig_fired), 1);
        rd_sel = 3'd0; #1; chk("R10 trig byte0", 128'(rd_data), 4);
        rd24(3'd0, v); chk("R8 trig pos", 128'(v), 4);
        for (int j = 0; j < 4; j++) cyc(1, 16'h1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0);
        rd24(3'd0, v); chk("R8 second trig ignored", 128'(v), 4);
        chk("R11 ratio 100 still capturing", 128'(capturing), 1);

        // Coincidence: stop with the seventh event
        cyc(0, 0, 0, 0, 1);
        for (int j = 0; j < 6; j++) cyc(1, 16'h0400 + 16'(j), 0, 0, 0);
        cyc(1, 16'hBEEF, 1, 0, 0);
        chk("R9 cluster at stop", 128'(cl_valid), 1);
        chk("R9 last event kept", 128'(ev_at(cl_data, 6)), 16'hBEEF);
        chk("R9 stopped", 128'(capturing), 0);
        rd24(3'd3, v); chk("R9 stop pos counts cluster", 128'(v), 8);

        // Post-trigger ratio 1 -> 2 clusters
        ratio = 7'd1;
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 0);
        rd24(3'd0, v); chk("R8 trig pos slot0", 128'(v), 1);
        for (int j = 0; j < 14; j++) cyc(1, 16'h2, 0, 0, 0);
        chk("R11 running at window end", 128'(capturing), 1);
        @(negedge clk);
        chk("R11 auto stop ratio1", 128'(capturing), 0);
        rd24(3'd3, v); chk("R11 stop pos", 128'(v), 16);

        // Ratio 0 -> stop right after trigger
        ratio = 7'd0;
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 0);
        chk("R11 ratio0 fired", 128'(capturing), 1);
        @(negedge clk);
        chk("R11 ratio0 stop", 128'(capturing), 0);

        // Ratio 120 clamps to 100 -> 255 clusters
        ratio = 7'd120;
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 0);
        for (int j = 0; j < 255 * 7; j++) cyc(1, 16'h3, 0, 0, 0);
        chk("R11 clamp running", 128'(capturing), 1);
        @(negedge clk);
        chk("R11 clamp stop", 128'(capturing), 0);
        rd24(3'd3, v); chk("R11 clamp stop pos", 128'(v), 255 * 8);

        // Reset mid-capture R1
        cyc(0, 0, 0, 0, 1);
        rst = 1; @(negedge clk); rst = 0;
        chk("R1 reset again", 128'(capturing), 0);
        rd24(3'd3, v); chk("R1 stop pos cleared", 128'(v), 0);

        finish_run();
    end

endmodule